// File: doc/BRIEF.md
# Unaligned Load Splitting Unit

This unit sits between a load requester and a memory bus that only moves whole 32-bit words. A requester asks for 1, 2 or 4 bytes at any byte address. The unit works out from the low address bits whether those bytes fall inside one bus word or run into the next word. It then performs one or two word reads. It shifts the fetched words into place, joins them into a little-endian value, and returns that value zero-extended or sign-extended to 32 bits.

A strict-mode input makes the unit refuse misaligned requests. In strict mode such a request gets an error response and starts no bus read. A request is handled as a complete transaction: the unit accepts a new request only after it has returned the previous response. The bus side allows one read in flight at a time.

Top module: `unalignedLoadUnit`

## Requirements
- R1: While reset is applied and on the first cycle after it, `busReq` and `rspValid` are low and `reqReady` is high.
- R2: Every bus address has its two low bits cleared. The first read of a request goes to the word that holds the start address. A second read, if there is one, goes to the word address plus 4.
- R3: `reqSize` encodes the width as 0 = 1 byte, 1 = 2 bytes, and 2 or 3 = 4 bytes. Byte k of a bus word is on bits [8k+7:8k]. The result holds the requested bytes in ascending address order, starting at bit 0.
- R4: A request whose bytes all lie in one word (start offset plus width at most 4) uses exactly one bus read. This includes every 1-byte request and a 2-byte request at offset 1.
- R5: A request that runs past the end of its word uses exactly two bus reads. The returned value joins the upper part of the first word with the lower part of the second word.
- R6: When `reqSigned` is 0, the bits of `rspData` above the requested width are zero.
- R7: When `reqSigned` is 1, the bits of `rspData` above the requested width copy the top bit of the highest requested byte.
- R8: When `strictMode` is 1, a misaligned request gets `rspErr` = 1 and `rspData` = 0, and issues no bus read. A 2-byte request is misaligned when address bit 0 is 1. A 4-byte request is misaligned when either address bit 0 or bit 1 is 1. With `strictMode` at 0, `rspErr` stays 0.
- R9: Once `busReq` is raised, it stays high with `busAddr` unchanged until a cycle in which `busGnt` is high.
- R10: `reqReady` drops on the cycle after a request is accepted and stays low until the cycle after the response. Each accepted request gets exactly one response, and `rspValid` is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strictMode | input | 1 | 1 = misaligned requests get an error response |
| reqValid | input | 1 | Load request present |
| reqReady | output | 1 | Unit idle and able to take a request |
| reqAddr | input | 32 | Byte address of the load |
| reqSize | input | 2 | Width code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| reqSigned | input | 1 | 1 = sign-extend the result |
| rspValid | output | 1 | Single-cycle response strobe |
| rspData | output | 32 | Assembled and extended load data |
| rspErr | output | 1 | Alignment error |
| busReq | output | 1 | Bus read request |
| busAddr | output | 32 | Word-aligned bus read address |
| busGnt | input | 1 | Bus accepts the request this cycle |
| busRvalid | input | 1 | Read data valid, at least one cycle after the grant |
| busRdata | input | 32 | Read data word |

## Verification
The main function is tried in four ways:
- Every width is swept over all four byte offsets. This separates requests that fit in one word, including a misaligned 2-byte request that still fits, from requests that need a second read. The number and addresses of the grants expose a wrong straddle decision.
- The same addresses are repeated with sign extension on and off. Memory bytes with the top bit set and bytes with it clear then show whether the extension bit is taken from the correct byte.
- Strict mode is run with both aligned and misaligned addresses. This separates the trapping path from normal loads.
- A random run varies grant and data delays, which tests the hold rule on the bus request and the joining of data across both reads.

// File: rtl/ldPkg.sv
package ldPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE0,
    ST_WAIT0,
    ST_ISSUE1,
    ST_WAIT1,
    ST_DONE
  } ldState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchReq;  // capture request fields
    logic errFlag;   // value for the error register on latchReq
    logic capLo;     // capture first bus word
    logic capHi;     // capture second bus word
    logic hiSel;     // address the following word
  } ldStrobe_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/ldCtrl.sv
module ldCtrl
  import ldPkg::*;
#(
  parameter int LANES = 4,
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strictMode,
  input  logic             reqValid,
  input  logic [OFF_W-1:0] reqOff,
  input  logic [1:0]       reqSize,
  output logic             reqReady,
  output logic             busReq,
  input  logic             busGnt,
  input  logic             busRvalid,
  output logic             rspValid,
  output ldStrobe_t        strobe
);

  localparam int CNT_W = OFF_W + 2;

  ldState_e state, stateNext;
  logic needTwo;
  logic [CNT_W-1:0] nBytes;
  logic [CNT_W-1:0] endPos;
  logic [OFF_W-1:0] lowMask;
  logic straddle;
  logic misal;
  logic accept;

  always_comb begin
    case (reqSize)
      SZ_BYTE: nBytes = CNT_W'(1);
      SZ_HALF: nBytes = CNT_W'(2);
      default: nBytes = CNT_W'(4);
    endcase
    endPos   = CNT_W'(reqOff) + nBytes;
    lowMask  = OFF_W'(nBytes - CNT_W'(1));
    straddle = endPos > CNT_W'(LANES);
    misal    = |(reqOff & lowMask);
  end

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign busReq   = (state == ST_ISSUE0) || (state == ST_ISSUE1);
  assign rspValid = (state == ST_DONE);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          if (strictMode && misal) begin
            strobe.errFlag = 1'b1;
            stateNext      = ST_DONE;
          end else begin
            stateNext = ST_ISSUE0;
          end
        end
      end
      ST_ISSUE0: if (busGnt) stateNext = ST_WAIT0;
      ST_WAIT0: begin
        if (busRvalid) begin
          strobe.capLo = 1'b1;
          stateNext    = needTwo ? ST_ISSUE1 : ST_DONE;
        end
      end
      ST_ISSUE1: begin
        strobe.hiSel = 1'b1;
        if (busGnt) stateNext = ST_WAIT1;
      end
      ST_WAIT1: begin
        if (busRvalid) begin
          strobe.capHi = 1'b1;
          stateNext    = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      needTwo <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) needTwo <= straddle;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busReq && !busGnt) |=> busReq); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid); // R10
  AST_READY_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> reqReady); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> !reqReady); // R10

endmodule

// File: rtl/ldDatapath.sv
module ldDatapath
  import ldPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  ldStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr
);

  logic [ADDR_W-1:0]   baseWord;
  logic [OFF_W-1:0]    offR;
  logic [1:0]          sizeR;
  logic                sgnR;
  logic                errR;
  logic [DATA_W-1:0]   loW;
  logic [DATA_W-1:0]   hiW;
  logic [2*DATA_W-1:0] shifted;
  logic [DATA_W-1:0]   raw;
  logic [DATA_W-1:0]   extended;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseWord <= '0;
      offR     <= '0;
      sizeR    <= '0;
      sgnR     <= 1'b0;
      errR     <= 1'b0;
      loW      <= '0;
      hiW      <= '0;
    end else begin
      if (strobe.latchReq) begin
        baseWord <= {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        offR     <= reqAddr[OFF_W-1:0];
        sizeR    <= reqSize;
        sgnR     <= reqSigned;
        errR     <= strobe.errFlag;
        hiW      <= '0;
      end
      if (strobe.capLo) loW <= busRdata;
      if (strobe.capHi) hiW <= busRdata;
    end
  end

  assign busAddr = baseWord + (strobe.hiSel ? ADDR_W'(LANES) : '0);

  // Join both words, then drop the bytes below the start offset
  assign shifted = {hiW, loW} >> {offR, 3'b000};
  assign raw     = shifted[DATA_W-1:0];

  always_comb begin
    case (sizeR)
      SZ_BYTE: extended = {{(DATA_W-8){sgnR & raw[7]}}, raw[7:0]};
      SZ_HALF: extended = {{(DATA_W-16){sgnR & raw[15]}}, raw[15:0]};
      default: extended = raw;
    endcase
  end

  assign rspData = errR ? '0 : extended;
  assign rspErr  = errR;

endmodule

// File: rtl/unalignedLoadUnit.sv
module unalignedLoadUnit
  import ldPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strictMode,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busGnt,
  input  logic              busRvalid,
  input  logic [DATA_W-1:0] busRdata
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  ldStrobe_t strobe;

  ldCtrl #(.LANES(LANES), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rst(rst), .strictMode(strictMode),
    .reqValid(reqValid), .reqOff(reqAddr[OFF_W-1:0]), .reqSize(reqSize),
    .reqReady(reqReady), .busReq(busReq), .busGnt(busGnt),
    .busRvalid(busRvalid), .rspValid(rspValid), .strobe(strobe)
  );

  ldDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqSigned(reqSigned),
    .busRdata(busRdata), .busAddr(busAddr),
    .rspData(rspData), .rspErr(rspErr)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busReq && !busGnt) |=> $stable(busAddr)); // R9
  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspErr) |-> !$past(busReq)); // R8

endmodule

// File: tb/unalignedLoadUnit_bench.sv
module unalignedLoadUnit_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        strictMode;
  logic        reqValid;
  logic        reqReady;
  logic [31:0] reqAddr;
  logic [1:0]  reqSize;
  logic        reqSigned;
  logic        rspValid;
  logic [31:0] rspData;
  logic        rspErr;
  logic        busReq;
  logic [31:0] busAddr;
  logic        busGnt;
  logic        busRvalid;
  logic [31:0] busRdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] grantQ[$];

  always #5 clk = ~clk;

  unalignedLoadUnit u_unalignedLoadUnit (
    .clk(clk), .rst(rst), .strictMode(strictMode),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqSigned(reqSigned),
    .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr),
    .busReq(busReq), .busAddr(busAddr), .busGnt(busGnt),
    .busRvalid(busRvalid), .busRdata(busRdata)
  );

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return 8'((a * 32'd13 + 32'd91) ^ (a >> 8));
  endfunction

  function automatic logic [31:0] memWord(input logic [31:0] w);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) v[8*k +: 8] = memByte({w[31:2], 2'b00} + 32'(k));
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Bus memory model with random grant and data delays; also checks the hold rule
  initial begin
    bit pend = 1'b0;
    int pendDelay = 0;
    int gntWait = 0;
    logic [31:0] latched = '0;
    bit waitingPrev = 1'b0;
    logic [31:0] prevAddr = '0;
    busGnt = 1'b0; busRvalid = 1'b0; busRdata = '0;
    forever begin
      @(negedge clk);
      if (!rst && waitingPrev) begin
        check(busReq && (busAddr == prevAddr), "R9", "request held until grant",
              busAddr, prevAddr);
      end
      waitingPrev = !rst && busReq && !busGnt;
      prevAddr = busAddr;
      busGnt = 1'b0;
      busRvalid = 1'b0;
      if (pend) begin
        if (pendDelay == 0) begin
          busRvalid = 1'b1;
          busRdata = memWord(latched);
          pend = 1'b0;
        end else pendDelay--;
      end else if (!rst && busReq) begin
        if (gntWait > 0) gntWait--;
        else begin
          busGnt = 1'b1;
          latched = busAddr;
          grantQ.push_back(busAddr);
          pend = 1'b1;
          pendDelay = int'($urandom_range(0, 2));
          gntWait = int'($urandom_range(0, 2));
          waitingPrev = 1'b0;
        end
      end
    end
  end

  task automatic doLoad(input logic [31:0] a, input logic [1:0] sz,
                        input logic sg, input logic strict);
    int nb;
    int off;
    bit mis, two, expErr;
    logic [31:0] val;
    int expGrants;
    int guard;
    logic [31:0] gotAddr;
    nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    off = int'(a[1:0]);
    mis = (off % nb) != 0;
    two = (off + nb) > 4;
    val = '0;
    for (int k = 0; k < nb; k++) val[8*k +: 8] = memByte(a + 32'(k));
    if (sg && val[8*nb-1]) for (int k = 8*nb; k < 32; k++) val[k] = 1'b1;
    expErr = strict && mis;
    expGrants = expErr ? 0 : (two ? 2 : 1);
    if (expErr) val = '0;

    @(negedge clk);
    strictMode = strict;
    grantQ.delete();
    reqValid = 1'b1; reqAddr = a; reqSize = sz; reqSigned = sg;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = $urandom; reqSize = 2'($urandom); reqSigned = 1'($urandom);
    check(!reqReady, "R10", "ready low after accept", 32'(reqReady), 32'd0);
    guard = 0;
    while (!rspValid && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    check(rspValid, "R10", "response arrives", 32'(rspValid), 32'd1);
    check(rspErr == expErr, "R8", "error flag", 32'(rspErr), 32'(expErr));
    check(rspData == val, sg ? "R7" : "R6", "data R3 R5", rspData, val);
    check(grantQ.size() == expGrants, two ? "R5" : "R4", "bus read count",
          32'(grantQ.size()), 32'(expGrants));
    if (grantQ.size() >= 1) begin
      gotAddr = grantQ[0];
      check(gotAddr == {a[31:2], 2'b00}, "R2", "first word address", gotAddr, {a[31:2], 2'b00});
    end
    if (grantQ.size() >= 2) begin
      gotAddr = grantQ[1];
      check(gotAddr == {a[31:2], 2'b00} + 32'd4, "R2", "second word address",
            gotAddr, {a[31:2], 2'b00} + 32'd4);
    end
    @(negedge clk);
    check(reqReady && !rspValid, "R10", "single-cycle response then idle",
          {30'd0, reqReady, rspValid}, 32'd2);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 150000, 0);
    finishRun();
  end

  initial begin
    rst = 1'b1; strictMode = 1'b0; reqValid = 1'b0;
    reqAddr = '0; reqSize = '0; reqSigned = 1'b0;
    repeat (3) @(negedge clk);
    check(!busReq && !rspValid && reqReady, "R1", "state during reset",
          {29'd0, busReq, rspValid, reqReady}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    check(!busReq && !rspValid && reqReady, "R1", "idle after reset",
          {29'd0, busReq, rspValid, reqReady}, 32'd1);

    // Every width at every offset, both extension modes (R3 R4 R5 R6 R7)
    for (int sz = 0; sz < 4; sz++)
      for (int o = 0; o < 4; o++)
        for (int sg = 0; sg < 2; sg++)
          doLoad(32'h0000_0100 + 32'(o) + 32'(sz * 16), 2'(sz), 1'(sg), 1'b0);
    // Word boundary at the top of a page and near address 0
    doLoad(32'h0000_0FFF, 2'd2, 1'b1, 1'b0);
    doLoad(32'h0000_0001, 2'd1, 1'b0, 1'b0);
    // Strict mode: misaligned traps, aligned and byte loads proceed (R8)
    doLoad(32'h0000_0201, 2'd1, 1'b0, 1'b1);
    doLoad(32'h0000_0202, 2'd2, 1'b1, 1'b1);
    doLoad(32'h0000_0203, 2'd3, 1'b0, 1'b1);
    doLoad(32'h0000_0204, 2'd2, 1'b1, 1'b1);
    doLoad(32'h0000_0203, 2'd0, 1'b1, 1'b1);
    doLoad(32'h0000_0206, 2'd1, 1'b1, 1'b1);
    // Random mix
    for (int i = 0; i < 60; i++)
      doLoad($urandom, 2'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));
    finishRun();
  end

endmodule